// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block follows a control transfer on endpoint zero through its phases. Four event inputs drive it: a SETUP packet has arrived (with its direction bit and requested length already decoded), a data packet has finished, the status stage has finished, and a stall is requested. From these it moves between five phases: waiting for or handling a SETUP, the IN data stage, the OUT data stage, waiting for the last IN packet to complete, and stalled. The block arms the transmit or receive side, holds the stall indication, allows the status stage, and pulses once when a whole transfer has ended. A function driver may ask for a delayed status stage. The status stage then waits for an explicit acknowledge.

A six-byte response buffer sits beside the sequencer. It is used for standard requests that are answered locally: a two-byte status reply or a six-byte exit-latency reply. Software-side logic writes the bytes by index and then starts a stream of a given length. The stream leaves on a valid/ready port. A byte moves only in a cycle where both valid and ready are high. While valid is high and ready is low, the data and last flag stay frozen. While a stream is running, new writes and new starts are ignored.

The phase codes are fixed and visible on `phase`: 1 = SETUP, 2 = IN data, 3 = OUT data, 4 = IN end wait, 5 = stalled. Every output is derived from registers, so a change shows in the cycle after the causing event is sampled.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset `phase` is 1 (SETUP), and `arm_tx`, `arm_rx`, `stall_out`, `status_go`, `xfer_done` and `rsp_valid` are all low.
- R2: On `setup_evt` the next phase is decoded as follows. With `setup_dir_in`=1 and nonzero `setup_len` it becomes 2. With `setup_dir_in`=0 and nonzero length it becomes 3. With zero length it becomes 1, and the status stage is pending, so `status_go` is high from the next cycle.
- R3: In phase 2, each `pkt_done` takes `pkt_bytes` off the remaining length. The phase moves to 4 when the packet is shorter than MPS or covers all of the remaining length. Otherwise it stays at 2. `arm_tx` is high only in phase 2.
- R4: In phase 4, the next `pkt_done` returns the machine to phase 1 with the status stage pending.
- R5: In phase 3, the same end rule as R3 applies, but the machine goes straight to phase 1 with the status stage pending. `arm_rx` is high only in phase 3.
- R6: `stall_req` in any phase gives phase 5 with `stall_out` high. In phase 5, `pkt_done`, `status_done` and `status_ack` have no effect. Only `setup_evt` leaves phase 5.
- R7: `setup_evt` in any phase aborts the current transfer and decodes afresh. It takes priority over `stall_req` and `status_done` in the same cycle.
- R8: `status_go` is high in phase 1 when the status stage is pending and not held. A `status_done` while `status_go` is high gives a one-cycle `xfer_done` pulse in the next cycle and clears the pending status. A `status_done` at any other time is ignored.
- R9: `dly_req`, sampled together with `setup_evt`, holds `status_go` low until a `status_ack` pulse. After that pulse the status stage is released. A `status_ack` when there is no hold changes nothing.
- R10: Response bytes are written at indices 0..5. A write with index 6 or 7 is ignored. `rsp_start` with length n streams bytes 0..n-1 in order. Lengths above 6 are clamped to 6, and a length of 0 starts nothing. `rsp_last` marks the final byte.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold steady. Writes and starts made while a stream is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_evt | input | 1 | SETUP packet received (one-cycle pulse) |
| setup_dir_in | input | 1 | Decoded direction: 1 = device to host |
| setup_len | input | LEN_W | Decoded requested data length |
| dly_req | input | 1 | Hold the status stage for this transfer (sampled with setup_evt) |
| stall_req | input | 1 | Request a protocol stall |
| pkt_done | input | 1 | A data packet has completed |
| pkt_bytes | input | PB_W | Byte count of the completed packet |
| status_done | input | 1 | Status stage completed |
| status_ack | input | 1 | Releases a held status stage |
| phase | output | 3 | Current phase code |
| arm_tx | output | 1 | Transmit side armed (IN data stage) |
| arm_rx | output | 1 | Receive side armed (OUT data stage) |
| stall_out | output | 1 | Endpoint is stalled |
| status_go | output | 1 | Status stage may proceed |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_wr_en | input | 1 | Response byte write strobe |
| rsp_wr_idx | input | 3 | Response byte index |
| rsp_wr_data | input | 8 | Response byte value |
| rsp_start | input | 1 | Start streaming the response |
| rsp_len | input | 3 | Number of bytes to stream |
| rsp_valid | output | 1 | Stream byte valid |
| rsp_ready | input | 1 | Stream consumer ready |
| rsp_data | output | 8 | Stream byte |
| rsp_last | output | 1 | Final byte of the stream |

## Verification
Two functions can fall in the same cycle: a new SETUP arriving while a stall request is raised, and a new SETUP arriving while a pending status stage completes. The bench drives each pair in the same cycle. It expects the fresh decode to win: the phase follows the new SETUP, no stall is shown, and no completion pulse appears. A third pairing raises a status completion while the status stage is still held. The bench judges this pairing from the missing pulse and from `status_go` rising only after the acknowledge.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [2:0] {
    PH_SETUP  = 3'd1,
    PH_IN     = 3'd2,
    PH_OUT    = 3'd3,
    PH_IN_END = 3'd4,
    PH_HALT   = 3'd5
  } ep0_phase_t;
endpackage

// File: rtl/ctl_ep_remain.sv
module ctl_ep_remain #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  parameter int PB_W  = $clog2(MPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             consume,
  input  logic [PB_W-1:0]  bytes,
  output logic             last_pkt
);
  localparam logic [PB_W-1:0] MPS_V = PB_W'(MPS);

  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] bytes_ext;

  assign bytes_ext = LEN_W'(bytes);
  // A short packet or one that covers the rest ends the data stage
  assign last_pkt  = consume && ((bytes < MPS_V) || (bytes_ext >= rem_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_len;
    end else if (consume) begin
      rem_q <= (bytes_ext >= rem_q) ? '0 : rem_q - bytes_ext;
    end
  end
endmodule

// File: rtl/ctl_ep_fsm.sv
module ctl_ep_fsm
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_evt,
  input  logic       dir_in,
  input  logic       len_zero,
  input  logic       dly_req,
  input  logic       stall_req,
  input  logic       pkt_done,
  input  logic       last_pkt,
  input  logic       status_done,
  input  logic       status_ack,
  output ep0_phase_t phase,
  output logic       status_go,
  output logic       xfer_done
);
  ep0_phase_t ph_q;
  logic       pend_q;
  logic       hold_q;
  logic       done_q;

  assign phase     = ph_q;
  assign status_go = (ph_q == PH_SETUP) && pend_q && !hold_q;
  assign xfer_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_SETUP;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (setup_evt) begin
        pend_q <= len_zero;
        hold_q <= dly_req;
        if (len_zero)    ph_q <= PH_SETUP;
        else if (dir_in) ph_q <= PH_IN;
        else             ph_q <= PH_OUT;
      end else if (stall_req) begin
        ph_q   <= PH_HALT;
        pend_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        if (status_ack && ph_q != PH_HALT) hold_q <= 1'b0;
        case (ph_q)
          PH_IN: begin
            if (pkt_done && last_pkt) ph_q <= PH_IN_END;
          end
          PH_IN_END: begin
            if (pkt_done) begin
              ph_q   <= PH_SETUP;
              pend_q <= 1'b1;
            end
          end
          PH_OUT: begin
            if (pkt_done && last_pkt) begin
              ph_q   <= PH_SETUP;
              pend_q <= 1'b1;
            end
          end
          PH_SETUP: begin
            if (status_done && status_go) begin
              pend_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_ep_rspbuf.sv
module ctl_ep_rspbuf #(
  parameter int DEPTH = 6,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  output logic             valid,
  input  logic             ready,
  output logic [7:0]       data,
  output logic             last
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem_q [DEPTH];
  logic             busy_q;
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_clamp;

  assign len_clamp = (start_len > DEPTH_C) ? DEPTH_C : start_len;
  assign valid     = busy_q;
  assign data      = mem_q[IDX_W'(ptr_q)];
  assign last      = busy_q && (ptr_q == cnt_q - 1'b1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (wr_en && !busy_q && (wr_idx == IDX_W'(g)))
        mem_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start && len_clamp != '0) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        cnt_q  <= len_clamp;
      end
    end else if (ready) begin
      if (last) busy_q <= 1'b0;
      else      ptr_q  <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  parameter int PB_W  = $clog2(MPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_evt,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             dly_req,
  input  logic             stall_req,
  input  logic             pkt_done,
  input  logic [PB_W-1:0]  pkt_bytes,
  input  logic             status_done,
  input  logic             status_ack,
  output logic [2:0]       phase,
  output logic             arm_tx,
  output logic             arm_rx,
  output logic             stall_out,
  output logic             status_go,
  output logic             xfer_done,
  input  logic             rsp_wr_en,
  input  logic [2:0]       rsp_wr_idx,
  input  logic [7:0]       rsp_wr_data,
  input  logic             rsp_start,
  input  logic [2:0]       rsp_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             rsp_last
);
  ep0_phase_t ph;
  logic       in_data;
  logic       last_pkt;

  assign in_data   = (ph == PH_IN) || (ph == PH_OUT);
  assign phase     = ph;
  assign arm_tx    = (ph == PH_IN);
  assign arm_rx    = (ph == PH_OUT);
  assign stall_out = (ph == PH_HALT);

  ctl_ep_remain #(.LEN_W(LEN_W), .MPS(MPS), .PB_W(PB_W)) u_rem (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (setup_evt),
    .load_len (setup_len),
    .consume  (pkt_done && in_data),
    .bytes    (pkt_bytes),
    .last_pkt (last_pkt)
  );

  ctl_ep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_evt   (setup_evt),
    .dir_in      (setup_dir_in),
    .len_zero    (setup_len == '0),
    .dly_req     (dly_req),
    .stall_req   (stall_req),
    .pkt_done    (pkt_done),
    .last_pkt    (last_pkt),
    .status_done (status_done),
    .status_ack  (status_ack),
    .phase       (ph),
    .status_go   (status_go),
    .xfer_done   (xfer_done)
  );

  ctl_ep_rspbuf #(.DEPTH(6), .IDX_W(3), .CNT_W(3)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rsp_wr_en),
    .wr_idx    (rsp_wr_idx),
    .wr_data   (rsp_wr_data),
    .start     (rsp_start),
    .start_len (rsp_len),
    .valid     (rsp_valid),
    .ready     (rsp_ready),
    .data      (rsp_data),
    .last      (rsp_last)
  );
endmodule

// File: rtl/ctl_ep_seq_chk.sv
module ctl_ep_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_evt,
  input logic             setup_dir_in,
  input logic [LEN_W-1:0] setup_len,
  input logic             stall_req,
  input logic             status_done,
  input logic             arm_tx,
  input logic             arm_rx,
  input logic             stall_out,
  input logic             status_go,
  input logic             xfer_done,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             rsp_last
);
  // R2: IN request with data arms the transmit side next cycle
  a_r2_in_decode: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && setup_dir_in && (setup_len != '0) |=> arm_tx);

  // R3 / R5 / R6: at most one of the phase indications at a time
  a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_tx, arm_rx, stall_out}));

  // R6: the stall persists until a SETUP arrives
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall_out && !setup_evt |=> stall_out);

  // R7: a SETUP always clears the stall
  a_r7_setup_unstall: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> !stall_out);

  // R8: completion pulse lasts one cycle and has an accepted status cause
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(status_done && status_go && !setup_evt));

  // R11: stream holds while stalled by the consumer
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));
endmodule

bind ctl_ep_seq ctl_ep_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .setup_evt    (setup_evt),
  .setup_dir_in (setup_dir_in),
  .setup_len    (setup_len),
  .stall_req    (stall_req),
  .status_done  (status_done),
  .arm_tx       (arm_tx),
  .arm_rx       (arm_rx),
  .stall_out    (stall_out),
  .status_go    (status_go),
  .xfer_done    (xfer_done),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_last     (rsp_last)
);

// File: tb/sim_ctl_ep_seq.sv
`timescale 1ns/1ps
module sim_ctl_ep_seq;
  localparam int LEN_W = 16;
  localparam int MPS   = 8;
  localparam int PB_W  = $clog2(MPS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_evt = 0, setup_dir_in = 0, dly_req = 0, stall_req = 0;
  logic [LEN_W-1:0] setup_len = '0;
  logic pkt_done = 0, status_done = 0, status_ack = 0;
  logic [PB_W-1:0] pkt_bytes = '0;
  logic [2:0] phase;
  logic arm_tx, arm_rx, stall_out, status_go, xfer_done;
  logic rsp_wr_en = 0, rsp_start = 0, rsp_ready = 0;
  logic [2:0] rsp_wr_idx = '0, rsp_len = '0;
  logic [7:0] rsp_wr_data = '0;
  logic rsp_valid, rsp_last;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctl_ep_seq #(.LEN_W(LEN_W), .MPS(MPS)) u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_setup(input bit dir, input int len, input bit dly);
    setup_evt = 1; setup_dir_in = dir; setup_len = LEN_W'(len); dly_req = dly;
    tick();
    setup_evt = 0; dly_req = 0;
  endtask

  task automatic do_pkt(input int b);
    pkt_done = 1; pkt_bytes = PB_W'(b);
    tick();
    pkt_done = 0;
  endtask

  task automatic do_status();
    status_done = 1;
    tick();
    status_done = 0;
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 37 + salt) & 255);
  endfunction

  task automatic wr_all(input int salt);
    for (int i = 0; i < 8; i++) begin
      rsp_wr_en = 1; rsp_wr_idx = 3'(i); rsp_wr_data = pat(i, salt);
      tick();
    end
    rsp_wr_en = 0;
  endtask

  task automatic stream(input int n, input int salt, input bit poke);
    int exp_n;
    int got;
    exp_n = (n > 6) ? 6 : n;
    got = 0;
    rsp_start = 1; rsp_len = 3'(n);
    tick();
    rsp_start = 0;
    for (int k = 0; k < 24 && got < exp_n; k++) begin
      rsp_ready = (k % 3 != 1);
      if (poke && k == 1) begin
        rsp_wr_en = 1; rsp_wr_idx = 3'd0; rsp_wr_data = 8'hEE;
        rsp_start = 1; rsp_len = 3'd1;
      end
      if (rsp_valid && rsp_ready) begin
        chk(rsp_data, pat(got, salt), "R10 stream byte");
        chk(rsp_last, (got == exp_n - 1), "R10 last flag");
        got++;
      end
      tick();
      rsp_wr_en = 0; rsp_start = 0;
    end
    rsp_ready = 0;
    chk(got, exp_n, "R10 byte count");
    chk(rsp_valid, 0, "R10 stream ended");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(phase, 1, "R1 phase");
    chk(arm_tx, 0, "R1 arm_tx");
    chk(arm_rx, 0, "R1 arm_rx");
    chk(stall_out, 0, "R1 stall");
    chk(status_go, 0, "R1 status_go");
    chk(xfer_done, 0, "R1 done");
    chk(rsp_valid, 0, "R1 rsp_valid");

    // Sweep of direction and length with full packets
    for (int dir = 0; dir < 2; dir++) begin
      for (int len = 0; len <= 20; len++) begin
        int rem;
        do_setup(dir[0], len, 0);
        if (len == 0) begin
          chk(phase, 1, "R2 zero length phase");
          chk(status_go, 1, "R2 zero length status");
        end else begin
          chk(phase, dir ? 2 : 3, "R2 decode");
          rem = len;
          while (rem > 0) begin
            int b;
            b = (rem < MPS) ? rem : MPS;
            do_pkt(b);
            rem -= b;
            if (dir == 1) begin
              chk(phase, (rem == 0) ? 4 : 2, "R3 IN progress");
              chk(arm_tx, (rem != 0), "R3 arm_tx");
            end else begin
              chk(phase, (rem == 0) ? 1 : 3, "R5 OUT progress");
              chk(arm_rx, (rem != 0), "R5 arm_rx");
            end
          end
          if (dir == 1) begin
            chk(status_go, 0, "R4 no status before completion");
            do_pkt(MPS);
            chk(phase, 1, "R4 back to setup");
          end
          chk(status_go, 1, "R4 R5 status pending");
        end
        do_status();
        chk(xfer_done, 1, "R8 done pulse");
        tick();
        chk(xfer_done, 0, "R8 pulse width");
        chk(status_go, 0, "R8 pending cleared");
      end
    end

    // R3 short packet ends IN stage early
    do_setup(1, 20, 0);
    do_pkt(3);
    chk(phase, 4, "R3 short packet");
    // R5 short packet ends OUT stage early
    do_setup(0, 20, 0);
    do_pkt(MPS);
    chk(phase, 3, "R5 full packet stays");
    do_pkt(2);
    chk(phase, 1, "R5 short packet");
    // R8 status_done with nothing pending
    do_status();
    chk(xfer_done, 1, "R8 first status accepted");
    tick();
    do_status();
    chk(xfer_done, 0, "R8 stray status ignored");

    // R6 stall from each phase
    for (int p = 1; p <= 4; p++) begin
      case (p)
        1: do_setup(0, 0, 0);
        2: do_setup(1, 9, 0);
        3: do_setup(0, 9, 0);
        default: begin do_setup(1, 4, 0); do_pkt(4); end
      endcase
      stall_req = 1; tick(); stall_req = 0;
      chk(phase, 5, "R6 stall entered");
      chk(stall_out, 1, "R6 stall_out");
      do_pkt(MPS);
      status_ack = 1; do_status(); status_ack = 0;
      chk(phase, 5, "R6 events ignored");
      chk(xfer_done, 0, "R6 no done in stall");
      chk(status_go, 0, "R6 no status in stall");
      do_setup(0, 5, 0);
      chk(phase, 3, "R6 R7 setup leaves stall");
    end

    // R7 setup wins over stall request
    setup_evt = 1; stall_req = 1; setup_dir_in = 1; setup_len = 16'd7;
    tick();
    setup_evt = 0; stall_req = 0;
    chk(phase, 2, "R7 setup over stall");
    chk(stall_out, 0, "R7 no stall");
    // R7 abort mid-IN into OUT
    do_pkt(MPS);
    do_setup(0, 5, 0);
    chk(phase, 3, "R7 abort restart");
    // R7 setup wins over status completion
    do_setup(0, 0, 0);
    setup_evt = 1; status_done = 1; setup_dir_in = 0; setup_len = 16'd0;
    tick();
    setup_evt = 0; status_done = 0;
    chk(xfer_done, 0, "R7 status lost to setup");
    chk(status_go, 1, "R7 new status pending");
    do_status();
    chk(xfer_done, 1, "R7 later status ok");

    // R9 delayed status
    do_setup(0, 0, 1);
    chk(status_go, 0, "R9 held");
    do_status();
    chk(xfer_done, 0, "R9 done blocked");
    status_ack = 1; tick(); status_ack = 0;
    chk(status_go, 1, "R9 released");
    status_ack = 1; tick(); status_ack = 0;
    chk(status_go, 1, "R9 stray ack no effect");
    do_status();
    chk(xfer_done, 1, "R9 done after ack");
    do_setup(1, 3, 1);
    do_pkt(3);
    do_pkt(3);
    chk(phase, 1, "R9 IN with hold");
    chk(status_go, 0, "R9 IN hold");
    status_ack = 1; tick(); status_ack = 0;
    chk(status_go, 1, "R9 IN released");
    do_status();

    // R10 / R11 response buffer
    wr_all(11);
    for (int n = 0; n < 8; n++) stream(n, 11, 0);
    stream(6, 11, 1);
    stream(2, 11, 0);
    wr_all(90);
    stream(7, 90, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule